// File: doc/BRIEF.md
# Video Output Underflow Concealment

This block sits between a pixel FIFO, which a DMA engine fills, and an 8-bit streaming video output. A horizontal sync rising edge starts each line. After a programmable offset, counted in pixel slots, the block reads the FIFO and presents one pixel per slot. A slot is two clock cycles long. A qualifier output marks every pixel that is presented.

The block has two modes. In direct mode the output cadence never breaks. If the FIFO is empty when a pixel is due, the block sends a fill pixel instead: either a grey value that suits the sample type, or a repeat of the last pixel sent. Each of these missed reads is counted. Once data returns, the block drops one late word after every pixel it sends, and keeps doing so until the count reaches zero. In line-memory mode an empty FIFO makes the block wait, and the qualifier acts as the write enable of a downstream line memory. An HS edge restarts the line. A VS edge returns the block to idle and latches the field identifier.

The controller has four states. `ST_IDLE` waits for HS. `ST_OFFSET` counts the horizontal offset. `ST_ACTIVE` reads and sends pixels. `ST_FLUSH` drains the words left over from a finished line. The transitions are:
- HS rising, from any state, goes to `ST_OFFSET`, or straight to `ST_ACTIVE` when the offset is zero.
- The end of the offset goes from `ST_OFFSET` to `ST_ACTIVE`.
- The last pixel of the line goes from `ST_ACTIVE` to `ST_FLUSH`.
- An empty FIFO goes from `ST_FLUSH` to `ST_IDLE`.
- VS rising, from any state, goes to `ST_IDLE`. It takes priority over HS.

Top module: `vout_underrun_conceal`

## Requirements
- R1: While reset is held and just after it is released, `pix_qual`, `fifo_rd` and `field_tag` are 0.
- R2: When an HS rising edge is sampled at clock edge E, the FIFO is not read before the offset has elapsed. The first pixel of the line appears with `pix_qual` high just after edge E + 2·`h_offset` + 2.
- R3: In direct mode (`line_mem_mode`=0), `pix_qual` is high for exactly one cycle in every two. This gives exactly `line_pixels` pixels per line, with no gaps, even while the FIFO is empty.
- R4: With `fill_hold`=0, a fill pixel is 8'h80 at even pixel indices and 8'h10 at odd pixel indices. Pixel index 0 is the first pixel after the line start, and the samples run in the order Cb, Y, Cr, Y.
- R5: With `fill_hold`=1, a fill pixel repeats the pixel sent just before it.
- R6: After g slots have been filled, each of the next g slots sends the oldest FIFO word and discards the word after it. After that, the word sent for slot k is the k-th word of the line.
- R7: At the end of a line the missed count is cleared, and FIFO words are popped until the FIFO is empty. The next line starts aligned, even if the catch-up had not finished.
- R8: In line-memory mode an empty FIFO never produces a fill pixel. The line's words come out in order, with none lost, and exactly `line_pixels` qualified pixels are produced.
- R9: An HS rising edge in the middle of a line restarts the offset and the pixel count. It cancels any pixel not yet sent, and reading continues from the current FIFO position.
- R10: A VS rising edge stops all output and reading until the next HS, and `field_tag` takes the level of `fid_in` at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line-locked clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| vs_in | input | 1 | Vertical sync level |
| hs_in | input | 1 | Horizontal sync level |
| fid_in | input | 1 | Field identifier level |
| line_mem_mode | input | 1 | 1 selects line-memory mode, 0 selects direct mode |
| fill_hold | input | 1 | 1 repeats the last pixel as fill, 0 uses grey |
| h_offset | input | OFF_W | Slots from HS to the first read |
| line_pixels | input | PIX_W | Pixels per line |
| fifo_empty | input | 1 | FIFO has no word |
| fifo_data | input | DW | FIFO word, valid the cycle after a read |
| fifo_rd | output | 1 | FIFO pop request |
| pix_data | output | DW | Output pixel |
| pix_qual | output | 1 | Pixel qualifier and line-memory write enable |
| field_tag | output | 1 | Field identifier captured at VS |

## Verification
The assertions take for granted the following about the inputs:
- `fifo_data` holds the popped word in the cycle after `fifo_rd`.
- The mode and fill inputs do not change while a line is active.
- HS and VS pulses last at least one cycle and do not rise together.

The stimulus changes the configuration only in the same cycle as the HS pulse that starts a line, while the block is idle. Its FIFO model returns data one cycle after each pop. Underflow is produced by limiting the number of visible words and then releasing them on a chosen slot, so every gap begins and ends on a known slot boundary.

// File: rtl/vuc_pkg.sv
`timescale 1ns/1ps
package vuc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_OFFSET,
        ST_ACTIVE,
        ST_FLUSH
    } vuc_state_e;

    localparam logic [7:0] GREY_LUMA   = 8'h10;
    localparam logic [7:0] GREY_CHROMA = 8'h80;
endpackage

// File: rtl/vuc_rise.sv
`timescale 1ns/1ps
module vuc_rise #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise
);
    logic [N-1:0] lvl_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lvl_q[i] <= 1'b0;
            else        lvl_q[i] <= lvl[i];
        end
    end

    assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/vuc_miss_ctr.sv
`timescale 1ns/1ps
module vuc_miss_ctr #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    input  logic         dec,
    output logic         pending
);
    localparam logic [W-1:0] MAXV = '1;
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             cnt <= '0;
        else if (clr)                           cnt <= '0;
        else if (inc && !dec && cnt != MAXV)    cnt <= cnt + 1'b1;
        else if (dec && !inc && cnt != '0)      cnt <= cnt - 1'b1;
    end

    assign pending = (cnt != '0);
endmodule

// File: rtl/vuc_fill_sel.sv
`timescale 1ns/1ps
module vuc_fill_sel
    import vuc_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          hold,
    input  logic          odd,
    input  logic [DW-1:0] last_pix,
    output logic [DW-1:0] fill
);
    always_comb begin
        if (hold)     fill = last_pix;
        else if (odd) fill = DW'(GREY_LUMA);
        else          fill = DW'(GREY_CHROMA);
    end
endmodule

// File: rtl/vout_underrun_conceal.sv
`timescale 1ns/1ps
module vout_underrun_conceal
    import vuc_pkg::*;
#(
    parameter int DW     = 8,
    parameter int OFF_W  = 8,
    parameter int PIX_W  = 12,
    parameter int MISS_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vs_in,
    input  logic             hs_in,
    input  logic             fid_in,
    input  logic             line_mem_mode,
    input  logic             fill_hold,
    input  logic [OFF_W-1:0] h_offset,
    input  logic [PIX_W-1:0] line_pixels,
    input  logic             fifo_empty,
    input  logic [DW-1:0]    fifo_data,
    output logic             fifo_rd,
    output logic [DW-1:0]    pix_data,
    output logic             pix_qual,
    output logic             field_tag
);
    vuc_state_e       state, nxt;
    logic             ph;
    logic [OFF_W-1:0] ocnt;
    logic [PIX_W-1:0] pcnt;
    logic             got;
    logic [1:0]       rises;
    logic             vs_rise, hs_rise, sync_evt;
    logic             slot0, slot1;
    logic             miss_pend, miss_inc, miss_dec, miss_clr;
    logic             line_done;
    logic [DW-1:0]    fill_val;

    vuc_rise #(.N(2)) u_rise (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   ({vs_in, hs_in}),
        .rise  (rises)
    );
    assign vs_rise  = rises[1];
    assign hs_rise  = rises[0];
    assign sync_evt = vs_rise | hs_rise;

    assign slot0 = (state == ST_ACTIVE) && !ph;
    assign slot1 = (state == ST_ACTIVE) && ph;

    always_comb begin
        fifo_rd = 1'b0;
        if (!sync_evt && !fifo_empty) begin
            if (slot0)                                      fifo_rd = 1'b1;
            else if (slot1 && !line_mem_mode && miss_pend)  fifo_rd = 1'b1;
            else if (state == ST_FLUSH)                     fifo_rd = 1'b1;
        end
    end

    assign miss_inc = slot0 && fifo_empty && !line_mem_mode;
    assign miss_dec = slot1 && fifo_rd;
    assign miss_clr = sync_evt || (state != ST_ACTIVE);

    vuc_miss_ctr #(.W(MISS_W)) u_miss (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (miss_clr),
        .inc     (miss_inc),
        .dec     (miss_dec),
        .pending (miss_pend)
    );

    vuc_fill_sel #(.DW(DW)) u_fill (
        .hold     (fill_hold),
        .odd      (pcnt[0]),
        .last_pix (pix_data),
        .fill     (fill_val)
    );

    assign line_done = slot1 && (got || !line_mem_mode)
                       && (pcnt == line_pixels - 1'b1);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   nxt = ST_IDLE;
            ST_OFFSET: if (ph && ocnt == h_offset - 1'b1) nxt = ST_ACTIVE;
            ST_ACTIVE: if (line_done) nxt = ST_FLUSH;
            ST_FLUSH:  if (fifo_empty) nxt = ST_IDLE;
        endcase
        if (vs_rise)      nxt = ST_IDLE;
        else if (hs_rise) nxt = (h_offset == '0) ? ST_ACTIVE : ST_OFFSET;
    end

    // State register and line counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            ph    <= 1'b0;
            ocnt  <= '0;
            pcnt  <= '0;
            got   <= 1'b0;
        end else begin
            state <= nxt;
            if (sync_evt) begin
                ph   <= 1'b0;
                ocnt <= '0;
                pcnt <= '0;
                got  <= 1'b0;
            end else begin
                ph  <= (state == ST_OFFSET || state == ST_ACTIVE) ? ~ph : 1'b0;
                got <= slot0 && !fifo_empty;
                if (state == ST_OFFSET && ph)
                    ocnt <= ocnt + 1'b1;
                if (slot1 && (got || !line_mem_mode))
                    pcnt <= pcnt + 1'b1;
            end
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pix_data  <= '0;
            pix_qual  <= 1'b0;
            field_tag <= 1'b0;
        end else begin
            pix_qual <= 1'b0;
            if (vs_rise)
                field_tag <= fid_in;
            if (!sync_evt && slot1) begin
                if (got) begin
                    pix_data <= fifo_data;
                    pix_qual <= 1'b1;
                end else if (!line_mem_mode) begin
                    pix_data <= fill_val;
                    pix_qual <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/vuc_checks.sv
`timescale 1ns/1ps
module vuc_checks (
    input logic clk,
    input logic rst_n,
    input logic vs_in,
    input logic hs_in,
    input logic fid_in,
    input logic line_mem_mode,
    input logic fifo_rd,
    input logic pix_qual,
    input logic field_tag
);
    // R1: outputs quiet in the cycle after a reset cycle
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!pix_qual && !fifo_rd && !field_tag));

    // R3: a qualified pixel is never followed by another in the next cycle
    a_r3_half_rate: assert property (@(posedge clk) disable iff (!rst_n)
        pix_qual |=> !pix_qual);

    // R8: in line-memory mode every qualified pixel comes from a read two cycles earlier
    a_r8_qual_from_read: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_qual && line_mem_mode) |-> $past(fifo_rd, 2));

    // R9: an HS edge cancels the pending pixel
    a_r9_hs_cancels: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_in) |=> !pix_qual);

    // R10: VS captures the field level and silences output
    a_r10_vs_field: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vs_in) |=> (field_tag == $past(fid_in) && !pix_qual));
endmodule

bind vout_underrun_conceal vuc_checks u_vuc_checks (
    .clk           (clk),
    .rst_n         (rst_n),
    .vs_in         (vs_in),
    .hs_in         (hs_in),
    .fid_in        (fid_in),
    .line_mem_mode (line_mem_mode),
    .fifo_rd       (fifo_rd),
    .pix_qual      (pix_qual),
    .field_tag     (field_tag)
);

// File: tb/test_vout_underrun_conceal.sv
`timescale 1ns/1ps
module test_vout_underrun_conceal;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vs_in = 1'b0, hs_in = 1'b0, fid_in = 1'b0;
    logic        line_mem_mode = 1'b0, fill_hold = 1'b0;
    logic [7:0]  h_offset = '0;
    logic [11:0] line_pixels = '0;
    logic        fifo_empty;
    logic [7:0]  fifo_data = '0;
    logic        fifo_rd;
    logic [7:0]  pix_data;
    logic        pix_qual, field_tag;

    always #4 clk = ~clk;

    vout_underrun_conceal i_vout_underrun_conceal (
        .clk(clk), .rst_n(rst_n), .vs_in(vs_in), .hs_in(hs_in), .fid_in(fid_in),
        .line_mem_mode(line_mem_mode), .fill_hold(fill_hold),
        .h_offset(h_offset), .line_pixels(line_pixels),
        .fifo_empty(fifo_empty), .fifo_data(fifo_data), .fifo_rd(fifo_rd),
        .pix_data(pix_data), .pix_qual(pix_qual), .field_tag(field_tag)
    );

    // FIFO model: words visible up to 'avail', data one cycle after pop
    logic [7:0] mem [0:127];
    int rp = 0;
    int avail = 0;
    assign fifo_empty = (rp >= avail);
    always @(posedge clk) if (fifo_rd) begin
        fifo_data <= mem[rp[6:0]];
        rp <= rp + 1;
    end

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int nchk = 0, nfail = 0;
    bit done = 1'b0;
    logic [7:0] cap_d [0:63];
    int cap_c [0:63];
    int nc = 0;

    typedef struct packed {
        logic       lm;
        logic       hold;
        logic [3:0] hoff;
        logic [5:0] len;
        logic [5:0] gat;
        logic [3:0] glen;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VEC [0:NV-1] = '{
        '{1'b0, 1'b0, 4'd2, 6'd8,  6'd0, 4'd0},
        '{1'b0, 1'b0, 4'd1, 6'd10, 6'd3, 4'd2},
        '{1'b0, 1'b1, 4'd0, 6'd8,  6'd2, 4'd3},
        '{1'b0, 1'b0, 4'd1, 6'd6,  6'd2, 4'd3},
        '{1'b0, 1'b0, 4'd0, 6'd4,  6'd0, 4'd0},
        '{1'b1, 1'b0, 4'd2, 6'd8,  6'd3, 4'd2},
        '{1'b1, 1'b0, 4'd0, 6'd4,  6'd0, 4'd0}
    };

    function automatic logic [7:0] wd(int i);
        return 8'(32 + i);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic start_line(input logic lm, input logic hold, input int hoff,
                              input int len, output int e0);
        @(negedge clk);
        line_mem_mode = lm;
        fill_hold     = hold;
        h_offset      = 8'(hoff);
        line_pixels   = 12'(len);
        hs_in         = 1'b1;
        e0            = cyc + 1;
        nc            = 0;
    endtask

    task automatic capture(input int ncyc, input int rel, input int rel_avail);
        for (int i = 0; i < ncyc; i++) begin
            @(negedge clk);
            if (i == 0) hs_in = 1'b0;
            if (cyc == rel) avail = rel_avail;
            if (pix_qual && nc < 64) begin
                cap_d[nc] = pix_data;
                cap_c[nc] = cyc;
                nc++;
            end
        end
    endtask

    initial begin
        #800000;
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        int e0, e1, base, gend;
        logic [7:0] ex, prev;
        string tag;
        for (int i = 0; i < 128; i++) mem[i] = wd(i);

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 qual in reset", int'(pix_qual), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 qual", int'(pix_qual), 0);
        chk("R1 rd", int'(fifo_rd), 0);
        chk("R1 field", int'(field_tag), 0);

        // Table walk
        for (int n = 0; n < NV; n++) begin
            vec_t v;
            v = VEC[n];
            base = rp;
            avail = base + ((v.glen != 0) ? int'(v.gat) : int'(v.len) + 2);
            start_line(v.lm, v.hold, int'(v.hoff), int'(v.len), e0);
            capture(2 * int'(v.hoff) + 2 * (int'(v.len) + int'(v.glen)) + 20,
                    (v.glen != 0) ? e0 + 2 * int'(v.hoff) + 2 * (int'(v.gat) + int'(v.glen)) : -1,
                    base + int'(v.len) + 2);
            chk(v.lm ? "R8 pixel count" : "R3 pixel count", nc, int'(v.len));
            chk("R2 first pixel cycle", cap_c[0], e0 + 2 * int'(v.hoff) + 2);
            gend = int'(v.gat) + int'(v.glen);
            prev = 8'h00;
            for (int k = 0; k < int'(v.len) && k < nc; k++) begin
                if (v.lm || v.glen == 0 || k < int'(v.gat)) begin
                    ex  = wd(base + k);
                    tag = v.lm ? "R8 data" : (n == 4 ? "R7 aligned data" : "R3 data");
                end else if (k < gend) begin
                    ex  = v.hold ? prev : ((k % 2) ? 8'h10 : 8'h80);
                    tag = v.hold ? "R5 fill" : "R4 fill";
                end else if (k - gend < int'(v.glen)) begin
                    ex  = wd(base + int'(v.gat) + 2 * (k - gend));
                    tag = "R6 catch-up";
                end else begin
                    ex  = wd(base + k);
                    tag = "R6 realigned";
                end
                chk(tag, int'(cap_d[k]), int'(ex));
                if (!v.lm && k > 0) chk("R3 spacing", cap_c[k] - cap_c[k-1], 2);
                prev = ex;
            end
            chk("R7 flushed", rp, base + int'(v.len) + 2);
        end

        // R10: VS captures field level
        @(negedge clk); fid_in = 1'b1; vs_in = 1'b1;
        @(negedge clk); vs_in = 1'b0;
        chk("R10 field tag high", int'(field_tag), 1);

        // R10: VS in mid line stops output
        base = rp;
        avail = base + 10;
        start_line(1'b0, 1'b0, 1, 8, e0);
        capture(7, -1, 0);
        chk("R10 pixels before VS", nc, 2);
        fid_in = 1'b0; vs_in = 1'b1;
        @(negedge clk); vs_in = 1'b0;
        chk("R10 field tag low", int'(field_tag), 0);
        capture(30, -1, 0);
        chk("R10 no output after VS", nc, 2);
        avail = rp;

        // R9: HS retrigger in line-memory mode
        base = rp;
        avail = base + 14;
        start_line(1'b1, 1'b0, 1, 6, e0);
        capture(9, -1, 0);
        chk("R9 pixels before retrigger", nc, 3);
        hs_in = 1'b1;
        e1 = cyc + 1;
        nc = 0;
        capture(2 + 12 + 20, -1, 0);
        chk("R9 pixel count after retrigger", nc, 6);
        chk("R9 restart timing", cap_c[0], e1 + 4);
        for (int k = 0; k < 6 && k < nc; k++)
            chk("R9 data after retrigger", int'(cap_d[k]), int'(wd(base + 3 + k)));
        chk("R9 flushed", rp, base + 14);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule